// File: doc/BRIEF.md
# Debug breakpoint comparator unit

This unit sits beside a CPU core and watches, every cycle, the address of the instruction about to execute and any data memory access. When a configured condition is met it sends a one-cycle break request, with a cause code, to a debug controller. The conditions are: single-stepping, any change of program flow, and four address comparator slots.

Slots 0 and 1 always compare program addresses. Slots 2 and 3 are combined slots. A 3-bit mode field gives each of them a role: program comparator, data comparator, or one half of a masked range comparator. In a range, slot 2 holds the address and slot 3 holds the mask. After a break is raised, further breaks are held back until the controller pulses a resume input. The unit is set up through a small synchronous register write port.

Top module: `brk_unit`

Register map on `cfg_addr`:
- Address 0 is the control word. Its bits are: [2:0] mode, [3] step enable, [4] flow enable, [8:5] slot enables (bit 5+i enables slot i), [10:9] access select of slot 2, [12:11] access select of slot 3.
- Addresses 1 to 4 hold the compare values of slots 0 to 3.

In an access select, bit 0 matches reads and bit 1 matches writes. The value 00 never matches.

Mode values:

| Mode | Slot 2 | Slot 3 |
|------|--------|--------|
| 0 | program | program |
| 1 | program | data |
| 2 | data | data |
| 3 | program range value | range mask |
| 4 | data range value | range mask |
| 5 to 7 | off | off |

Cause codes: 0 to 3 give the slot index, 4 means flow change, 5 means single step. A range match reports code 2.

## Requirements
- R1: After reset `brk` is 0 and `brk_cause` is 0. All slots, step and flow breaks are disabled.
- R2: A program slot matches only in a cycle where `instr_valid` is 1 and `pc` equals its value.
- R3: A data slot matches only when `daddr` equals its value and there is an access its select allows: a read with select bit 0 set, or a write with select bit 1 set.
- R4: The mode field assigns slots 2 and 3 as in the mode table. A slot does not compare the kind of address its role excludes.
- R5: In modes 3 and 4, slot 2 matches when `((addr ^ value2) & value3) == 0`. The address is `pc` in mode 3, qualified by `instr_valid`. It is `daddr` in mode 4, qualified by slot 2's access select. Slot 2's enable gates the range match, and slot 3 never reports on its own.
- R6: Mode values 5 to 7 keep slots 2 and 3 from ever matching.
- R7: A slot whose enable bit is 0 never matches.
- R8: With flow enable set, a cycle with `instr_valid` and `flow_chg` both 1 raises cause 4. `flow_chg` has no effect without `instr_valid`.
- R9: With step enable set, the first valid instruction after a resume executes without a break. The next valid instruction raises cause 5.
- R10: When several conditions hit in one cycle, the cause is the lowest-numbered hitting slot. Flow (4) comes after the slots, and step (5) comes last.
- R11: `brk` is a one-cycle pulse. After it, no break is raised until a cycle with `resume` = 1. Hits in that resume cycle are also held back.
- R12: `brk` and `brk_cause` are registered. They appear in the cycle after the qualifying inputs, and `brk_cause` holds until the next break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| instr_valid | input | 1 | `pc` holds an instruction about to execute |
| pc | input | ADDR_W | Program address |
| flow_chg | input | 1 | This instruction is reached by a change of program flow |
| dmem_rd | input | 1 | Data read strobe |
| dmem_wr | input | 1 | Data write strobe |
| daddr | input | ADDR_W | Data address |
| resume | input | 1 | Debug controller releases the break hold |
| brk | output | 1 | Break request pulse |
| brk_cause | output | 3 | Cause of the latest break |

## Verification
The assertions assume that `rst` is held for at least one clock edge before anything else is checked. They also assume that, when no strobe is active, `dmem_rd`, `dmem_wr` and `instr_valid` are cleanly 0 rather than unknown. The bench drives every input on the falling edge, so each input is stable across the rising edge. It returns all strobes to 0 after each tested cycle. It writes configuration only while no strobe is active, so a comparison never sees a half-written setting.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NSLOT = 4;
  localparam logic [2:0] CAUSE_FLOW = 3'd4;
  localparam logic [2:0] CAUSE_STEP = 3'd5;
  localparam logic [2:0] MODE_LAST = 3'd4;

  typedef enum logic [2:0] {K_OFF, K_PROG, K_DATA, K_PRNG, K_DRNG} kind_e;

  typedef struct packed {
    logic [1:0] rw3;
    logic [1:0] rw2;
    logic [3:0] en;
    logic       flow_en;
    logic       step_en;
    logic [2:0] mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic kind_e slot_kind(input logic [2:0] mode, input int idx);
    kind_e k;
    k = K_OFF;
    if (idx < 2) k = K_PROG;
    else if (idx == 2) begin
      case (mode)
        3'd0, 3'd1: k = K_PROG;
        3'd2:       k = K_DATA;
        3'd3:       k = K_PRNG;
        3'd4:       k = K_DRNG;
        default:    k = K_OFF;
      endcase
    end else if (idx == 3) begin
      case (mode)
        3'd0:       k = K_PROG;
        3'd1, 3'd2: k = K_DATA;
        default:    k = K_OFF;
      endcase
    end
    return k;
  endfunction
endpackage

// File: rtl/brk_cfg.sv
module brk_cfg
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int CFG_AW = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [ADDR_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] val [NSLOT]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (we && addr == '0) begin
      ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_val
    always_ff @(posedge clk) begin
      if (rst) val[i] <= '0;
      else if (we && addr == CFG_AW'(i + 1)) val[i] <= wdata;
    end
  end
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] val [NSLOT],
  input  logic              instr_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              dmem_rd,
  input  logic              dmem_wr,
  input  logic [ADDR_W-1:0] daddr,
  output logic [NSLOT-1:0]  hit
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int NX = (i + 1 < NSLOT) ? i + 1 : i;
    kind_e       kind;
    logic [1:0]  rw;
    logic        acc_ok;

    always_comb begin
      kind = slot_kind(ctrl.mode, i);
      rw = (i == 2) ? ctrl.rw2 : (i == 3) ? ctrl.rw3 : 2'b00;
      acc_ok = (rw[0] & dmem_rd) | (rw[1] & dmem_wr);
      case (kind)
        K_PROG:  hit[i] = ctrl.en[i] & instr_valid & (pc == val[i]);
        K_DATA:  hit[i] = ctrl.en[i] & acc_ok & (daddr == val[i]);
        K_PRNG:  hit[i] = ctrl.en[i] & instr_valid & (((pc ^ val[i]) & val[NX]) == '0);
        K_DRNG:  hit[i] = ctrl.en[i] & acc_ok & (((daddr ^ val[i]) & val[NX]) == '0);
        default: hit[i] = 1'b0;
      endcase
    end
  end

  // R2 R3: no strobe, no slot match
  a_r2_no_strobe_no_hit: assert property (@(posedge clk) disable iff (rst)
    (!instr_valid && !dmem_rd && !dmem_wr) |-> (hit == '0));

  // R6: illegal mode keeps combined slots silent
  a_r6_bad_mode_quiet: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mode > MODE_LAST) |-> (hit[3:2] == 2'b00));

  // R7: a disabled slot never matches
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    ((hit & ~ctrl.en) == '0));
endmodule

// File: rtl/brk_arb.sv
module brk_arb
  import brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [NSLOT-1:0] hit,
  input  logic             instr_valid,
  input  logic             flow_chg,
  input  logic             resume,
  output logic             brk,
  output logic [2:0]       brk_cause
);
  logic       halted, seen;
  logic       flow_hit, step_hit, any, fire;
  logic [2:0] code;

  always_comb begin
    flow_hit = ctrl.flow_en & instr_valid & flow_chg;
    step_hit = ctrl.step_en & instr_valid & seen;
    any = (|hit) | flow_hit | step_hit;
    fire = any & ~halted;
    code = CAUSE_STEP;
    if (flow_hit) code = CAUSE_FLOW;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (hit[i]) code = 3'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk <= 1'b0;
      brk_cause <= '0;
      halted <= 1'b0;
      seen <= 1'b0;
    end else begin
      brk <= fire;
      if (fire) brk_cause <= code;
      halted <= (halted & ~resume) | fire;
      if (resume || fire) seen <= 1'b0;
      else if (instr_valid && !halted) seen <= 1'b1;
    end
  end

  // R11: break is a single-cycle pulse
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
    brk |=> !brk);

  // R11: held back while halted and not resumed
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (halted && !resume) |=> !brk);

  // R12: cause only changes with a break
  a_r12_cause_stable: assert property (@(posedge clk) disable iff (rst)
    !brk |-> $stable(brk_cause));

  // R10: cause code is always a legal value
  a_r10_cause_legal: assert property (@(posedge clk) disable iff (rst)
    brk |-> (brk_cause <= CAUSE_STEP));
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              instr_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              flow_chg,
  input  logic              dmem_rd,
  input  logic              dmem_wr,
  input  logic [ADDR_W-1:0] daddr,
  input  logic              resume,
  output logic              brk,
  output logic [2:0]        brk_cause
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] val [NSLOT];
  logic [NSLOT-1:0]  hit;

  brk_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .val(val)
  );

  brk_match #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .ctrl(ctrl), .val(val), .instr_valid(instr_valid),
    .pc(pc), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .daddr(daddr), .hit(hit)
  );

  brk_arb u_arb (
    .clk(clk), .rst(rst), .ctrl(ctrl), .hit(hit), .instr_valid(instr_valid),
    .flow_chg(flow_chg), .resume(resume), .brk(brk), .brk_cause(brk_cause)
  );
endmodule

// File: tb/tb_brk_unit.sv
module tb_brk_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic instr_valid = 0, flow_chg = 0, dmem_rd = 0, dmem_wr = 0, resume = 0;
  logic [AW-1:0] pc = 0, daddr = 0;
  logic brk;
  logic [2:0] brk_cause;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .instr_valid(instr_valid), .pc(pc), .flow_chg(flow_chg), .dmem_rd(dmem_rd),
    .dmem_wr(dmem_wr), .daddr(daddr), .resume(resume), .brk(brk), .brk_cause(brk_cause)
  );

  function automatic logic [AW-1:0] mk(input logic [2:0] mode, input logic st,
      input logic fl, input logic [3:0] en, input logic [1:0] rw2, input logic [1:0] rw3);
    return AW'({rw3, rw2, en, fl, st, mode});
  endfunction

  task automatic wr_cfg(input logic [2:0] a, input logic [AW-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  // one cycle of CPU activity, sampled on the following falling edge
  task automatic cyc(input logic iv, input logic [AW-1:0] p, input logic fc,
      input logic rd, input logic wr, input logic [AW-1:0] da, input logic rs);
    instr_valid = iv; pc = p; flow_chg = fc; dmem_rd = rd; dmem_wr = wr;
    daddr = da; resume = rs;
    @(posedge clk); @(negedge clk);
    instr_valid = 0; flow_chg = 0; dmem_rd = 0; dmem_wr = 0; resume = 0;
  endtask

  task automatic expect_brk(input string req, input logic eb, input logic [2:0] ec);
    n_chk++;
    if (brk !== eb || (eb && brk_cause !== ec)) begin
      n_fail++;
      $display("FAIL %s: brk=%0b cause=%0d expected brk=%0b cause=%0d",
               req, brk, brk_cause, eb, ec);
    end
  endtask

  task automatic do_resume();
    cyc(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    expect_brk("R1 reset", 0, 0);
    n_chk++;
    if (brk_cause !== 3'd0) begin
      n_fail++;
      $display("FAIL R1 reset cause: actual %0d expected 0", brk_cause);
    end
    cyc(1, 16'h0000, 1, 1, 1, 16'h0000, 0);
    expect_brk("R1 all disabled after reset", 0, 0);
  endtask

  task automatic t_prog();
    wr_cfg(1, 16'h0100); wr_cfg(2, 16'h0200);
    wr_cfg(0, mk(0, 0, 0, 4'b0011, 0, 0));
    cyc(0, 16'h0100, 0, 0, 0, 0, 0);
    expect_brk("R2 no instr_valid", 0, 0);
    cyc(1, 16'h0100, 0, 0, 0, 0, 0);
    expect_brk("R2 R12 slot0 hit next cycle", 1, 0);
    do_resume();
    cyc(1, 16'h0200, 0, 0, 0, 0, 0);
    expect_brk("R2 slot1 hit", 1, 1);
    do_resume();
    cyc(1, 16'h0300, 0, 0, 0, 0, 0);
    expect_brk("R2 no match", 0, 0);
    cyc(0, 0, 0, 1, 0, 16'h0100, 0);
    expect_brk("R2 data access ignored by program slot", 0, 0);
  endtask

  task automatic t_prio_enable();
    wr_cfg(1, 16'h0040); wr_cfg(2, 16'h0040);
    wr_cfg(0, mk(0, 0, 1, 4'b0011, 0, 0));
    cyc(1, 16'h0040, 1, 0, 0, 0, 0);
    expect_brk("R10 lowest slot wins over slot1 and flow", 1, 0);
    do_resume();
    wr_cfg(0, mk(0, 0, 1, 4'b0010, 0, 0));
    cyc(1, 16'h0040, 1, 0, 0, 0, 0);
    expect_brk("R7 R10 slot0 disabled, slot1 reported", 1, 1);
    do_resume();
    wr_cfg(0, mk(0, 0, 1, 4'b0000, 0, 0));
    cyc(1, 16'h0040, 1, 0, 0, 0, 0);
    expect_brk("R7 R10 all slots off, flow reported", 1, 4);
    do_resume();
    wr_cfg(0, mk(0, 0, 0, 4'b0000, 0, 0));
    cyc(1, 16'h0040, 0, 0, 0, 0, 0);
    expect_brk("R7 disabled slots silent", 0, 0);
  endtask

  task automatic t_modes();
    wr_cfg(3, 16'h0500); wr_cfg(4, 16'h0600);
    wr_cfg(0, mk(1, 0, 0, 4'b1100, 2'b00, 2'b10));
    cyc(1, 16'h0500, 0, 0, 0, 0, 0);
    expect_brk("R4 mode1 slot2 program", 1, 2);
    do_resume();
    cyc(0, 0, 0, 1, 0, 16'h0600, 0);
    expect_brk("R3 write-only slot ignores read", 0, 0);
    cyc(0, 0, 0, 0, 1, 16'h0600, 0);
    expect_brk("R3 R4 mode1 slot3 data write", 1, 3);
    do_resume();
    cyc(1, 16'h0600, 0, 0, 0, 0, 0);
    expect_brk("R4 data slot ignores pc", 0, 0);
    wr_cfg(0, mk(2, 0, 0, 4'b1100, 2'b01, 2'b11));
    cyc(0, 0, 0, 1, 0, 16'h0500, 0);
    expect_brk("R3 R4 mode2 slot2 read", 1, 2);
    do_resume();
    cyc(0, 0, 0, 0, 1, 16'h0500, 0);
    expect_brk("R3 read-only slot ignores write", 0, 0);
    cyc(1, 16'h0500, 0, 0, 0, 0, 0);
    expect_brk("R4 mode2 slot2 ignores pc", 0, 0);
  endtask

  task automatic t_range();
    wr_cfg(3, 16'h1230); wr_cfg(4, 16'hFFF0);
    wr_cfg(0, mk(3, 0, 0, 4'b0100, 2'b11, 2'b00));
    cyc(1, 16'h1234, 0, 0, 0, 0, 0);
    expect_brk("R5 program range inside", 1, 2);
    do_resume();
    cyc(1, 16'h1334, 0, 0, 0, 0, 0);
    expect_brk("R5 program range outside", 0, 0);
    cyc(0, 0, 0, 1, 0, 16'h1234, 0);
    expect_brk("R5 program range ignores data", 0, 0);
    cyc(1, 16'hFFF0, 0, 0, 0, 0, 0);
    expect_brk("R5 mask value not matched by slot3", 0, 0);
    wr_cfg(0, mk(4, 0, 0, 4'b0100, 2'b11, 2'b00));
    cyc(0, 0, 0, 0, 1, 16'h123F, 0);
    expect_brk("R5 data range inside", 1, 2);
    do_resume();
    cyc(1, 16'h1234, 0, 0, 0, 0, 0);
    expect_brk("R5 data range ignores pc", 0, 0);
  endtask

  task automatic t_bad_mode();
    wr_cfg(3, 16'h0700); wr_cfg(4, 16'h0700);
    wr_cfg(0, mk(6, 0, 0, 4'b1100, 2'b11, 2'b11));
    cyc(1, 16'h0700, 0, 1, 1, 16'h0700, 0);
    expect_brk("R6 illegal mode disables slots 2 and 3", 0, 0);
  endtask

  task automatic t_flow();
    wr_cfg(0, mk(0, 0, 1, 4'b0000, 0, 0));
    cyc(0, 16'h9000, 1, 0, 0, 0, 0);
    expect_brk("R8 flow_chg without instr_valid", 0, 0);
    cyc(1, 16'h9000, 1, 0, 0, 0, 0);
    expect_brk("R8 flow change", 1, 4);
    do_resume();
  endtask

  task automatic t_step();
    wr_cfg(0, mk(0, 1, 0, 4'b0000, 0, 0));
    do_resume();
    cyc(1, 16'h0010, 0, 0, 0, 0, 0);
    expect_brk("R9 first instruction runs", 0, 0);
    cyc(0, 16'h0000, 0, 0, 0, 0, 0);
    expect_brk("R9 idle cycle", 0, 0);
    cyc(1, 16'h0011, 0, 0, 0, 0, 0);
    expect_brk("R9 step break", 1, 5);
    do_resume();
    cyc(1, 16'h0012, 0, 0, 0, 0, 0);
    expect_brk("R9 first after resume runs", 0, 0);
    wr_cfg(0, mk(0, 0, 0, 4'b0000, 0, 0));
  endtask

  task automatic t_hold();
    wr_cfg(1, 16'h0010);
    wr_cfg(0, mk(0, 0, 0, 4'b0001, 0, 0));
    do_resume();
    cyc(1, 16'h0010, 0, 0, 0, 0, 0);
    expect_brk("R11 first hit", 1, 0);
    cyc(1, 16'h0010, 0, 0, 0, 0, 0);
    expect_brk("R11 pulse ends, hit held back", 0, 0);
    cyc(1, 16'h0010, 0, 0, 0, 0, 0);
    expect_brk("R11 still held back", 0, 0);
    cyc(1, 16'h0010, 0, 0, 0, 0, 1);
    expect_brk("R11 hit in resume cycle held back", 0, 0);
    n_chk++;
    if (brk_cause !== 3'd0) begin
      n_fail++;
      $display("FAIL R12 cause hold: actual %0d expected 0", brk_cause);
    end
    cyc(1, 16'h0010, 0, 0, 0, 0, 0);
    expect_brk("R11 break after resume", 1, 0);
    do_resume();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_prog();
    t_prio_enable();
    t_modes();
    t_range();
    t_bad_mode();
    t_flow();
    t_step();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule